// File: doc/BRIEF.md
# Smart Card Character Transmitter

This block sends bytes over a half-duplex, open-drain smart card I/O line in the ISO 7816 character format. Each character is a low start bit, eight data bits and an even parity bit, one elementary time unit (etu) per bit. The etu length is a count of system clock cycles taken from an input. After the parity bit the transmitter releases the line and looks for a receiver error signal. If the receiver pulls the line low at that point, the block sets a sticky error flag and automatically sends the same byte again.

Software writes a byte into a holding register. The block moves that byte into its shift register as soon as the line is free and marks the move with a one-cycle pulse. A transmit-end flag, with its own one-cycle pulse, marks the end of a successful character when no further byte is waiting. Where that end point falls depends on a guard-mode input. The line itself is modelled as an open-drain pull-down output together with an input that reads the wired line level.

Top module: `sc_char_tx`

## Requirements
- R1: While busy, the line is pulled low exactly for 0-valued bits of the character. Half-etu positions 0-1 carry the low start bit, positions 2 to 17 carry the eight data bits, and positions 18-19 carry a parity bit chosen so that the ones among the data and parity bits are even. A character starts in the cycle after the load edge, with `io_pull_low` high.
- R2: With `msb_first`=0 the data bits go out D0 first. With `msb_first`=1 they go out D7 first.
- R3: From 10 etu after the start edge until the character slot ends, the pull-down is off. The pull-down is never on while `busy` is low.
- R4: The line is sampled at the clock edge 10.5 etu after the start edge. If it is low there, `ers` is set and the same byte is sent again, with the new start edge 13 etu after the previous one. This repeats until a character goes through without an error.
- R5: A write loads the holding register, and `tdr_empty` goes low after the write edge. When idle, the byte moves to the shift register on the next edge. After a successful character with a byte waiting, it moves at the slot end. On each move, `txi` pulses for one cycle and `tdr_empty` goes high, unless a write hits the same edge.
- R6: `tend` is 1 after reset and is cleared by a write. It is set, with a one-cycle `tei` pulse, 12.5 etu after the start edge when `guard_mode`=0, or 11.0 etu after it when `guard_mode`=1. This happens only if that character saw no error and the holding register is empty at that point.
- R7: After a successful character, a waiting byte starts 13 etu after the previous start edge when `guard_mode`=0, or 12 etu after it when `guard_mode`=1. With nothing waiting, `busy` falls at that same point.
- R8: `ers` stays set until an `err_clr` cycle. If an error is sampled in the same cycle as a clear, the set wins. Clearing the flag does not change the character in progress.
- R9: One etu is `etu_cycles` clock cycles, where `etu_cycles` is an even number of at least 2. All timing points above scale with it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| etu_cycles | input | ETU_W | Clock cycles per etu (even, at least 2) |
| msb_first | input | 1 | 1: D7 sent first; 0: D0 sent first |
| guard_mode | input | 1 | Selects the transmit-end point and slot length |
| wr_en | input | 1 | Write strobe for the holding register |
| wr_data | input | DATA_W | Byte to send |
| err_clr | input | 1 | Clears the error flag |
| io_line | input | 1 | Sensed level of the wired I/O line |
| io_pull_low | output | 1 | Open-drain driver enable: 1 pulls the line low |
| busy | output | 1 | A character slot is in progress |
| tdr_empty | output | 1 | Holding register is free |
| txi | output | 1 | One-cycle pulse when a byte moves to the shift register |
| tend | output | 1 | Transmit-end flag |
| tei | output | 1 | One-cycle pulse when `tend` is set |
| ers | output | 1 | Sticky error-signal flag |

## Verification
The bench builds the block with `ETU_W`=6. It runs at 4 cycles per etu and at 10 cycles per etu, so that both guard modes, both bit orders and repeated retransmissions fit into a few thousand cycles. The odd half-etu sample point lands on a whole cycle in both cases. At 10 cycles per etu, the measured distances between load and transmit-end pulses separate the 11.0 and 13 etu points from off-by-one-half-etu errors. A modelled receiver rejects chosen characters, so the 26 half-etu retransmit slot and the sticky error flag are exercised back to back with a queued byte.

// File: rtl/sc_tx_pkg.sv
package sc_tx_pkg;

  typedef enum logic {
    ORDER_LSB = 1'b0,
    ORDER_MSB = 1'b1
  } bit_order_e;

  // value of the parity bit that makes the ones count even
  function automatic logic even_fill(input logic [63:0] word, input int unsigned width);
    logic acc;
    acc = 1'b0;
    for (int i = 0; i < 64; i++) begin
      if (i < width) acc = acc ^ word[i];
    end
    return acc;
  endfunction

endpackage

// File: rtl/sc_etu_tick.sv
// Half-etu strobe: pulses once every etu_cycles/2 clocks while run is high.
module sc_etu_tick #(
  parameter int ETU_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [ETU_W-1:0] etu_cycles,
  output logic             tick
);
  localparam logic [ETU_W-1:0] ONE = ETU_W'(1);

  logic [ETU_W-1:0] cyc;
  logic [ETU_W-1:0] half_len;

  always_comb begin
    half_len = etu_cycles >> 1;
    tick     = run && (cyc == half_len - ONE);
  end

  always_ff @(posedge clk) begin
    if (rst || !run || tick) cyc <= '0;
    else                     cyc <= cyc + ONE;
  end
endmodule

// File: rtl/sc_frame_gen.sv
// Maps a bit slot (half-etu position / 2) and the shift register to the
// pull-down request for that slot.
module sc_frame_gen #(
  parameter int DATA_W = 8,
  parameter int SW     = 4
) (
  input  logic [SW-1:0]     slot,
  input  logic [DATA_W-1:0] shreg,
  input  logic              msb_first,
  output logic              pull
);
  import sc_tx_pkg::*;

  localparam logic [SW-1:0] PAR_SLOT = SW'(DATA_W + 1);

  logic [DATA_W-1:0] reversed;
  logic [DATA_W-1:0] ordered;
  logic [DATA_W-1:0] hit;
  logic              data_bit;
  logic              par_bit;

  for (genvar g = 0; g < DATA_W; g++) begin : g_bits
    localparam logic [SW-1:0] SLOT_G = SW'(g + 1);
    assign reversed[g] = shreg[DATA_W-1-g];
    assign hit[g]      = (slot == SLOT_G);
  end

  always_comb begin
    ordered  = (bit_order_e'(msb_first) == ORDER_MSB) ? reversed : shreg;
    data_bit = |(hit & ordered);
    par_bit  = even_fill(64'(shreg), DATA_W);
    if (slot == '0)           pull = 1'b1;
    else if (|hit)            pull = !data_bit;
    else if (slot == PAR_SLOT) pull = !par_bit;
    else                      pull = 1'b0;
  end
endmodule

// File: rtl/sc_char_tx.sv
module sc_char_tx #(
  parameter int DATA_W = 8,
  parameter int ETU_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ETU_W-1:0]  etu_cycles,
  input  logic              msb_first,
  input  logic              guard_mode,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              err_clr,
  input  logic              io_line,
  output logic              io_pull_low,
  output logic              busy,
  output logic              tdr_empty,
  output logic              txi,
  output logic              tend,
  output logic              tei,
  output logic              ers
);
  localparam int HP_MAX = 2 * (DATA_W + 5);
  localparam int HP_W   = $clog2(HP_MAX + 1);
  localparam logic [HP_W-1:0] HP_ONE     = HP_W'(1);
  localparam logic [HP_W-1:0] HP_SAMPLE  = HP_W'(2 * (DATA_W + 2) + 1);
  localparam logic [HP_W-1:0] HP_TEND_G1 = HP_W'(2 * (DATA_W + 3));
  localparam logic [HP_W-1:0] HP_END_G1  = HP_W'(2 * (DATA_W + 4));
  localparam logic [HP_W-1:0] HP_TEND_G0 = HP_W'(2 * (DATA_W + 4) + 1);
  localparam logic [HP_W-1:0] HP_END_LNG = HP_W'(HP_MAX);

  logic [HP_W-1:0]   hp, hp_inc, hp_n, end_pt, tend_pt;
  logic [DATA_W-1:0] tdr, tsr, tsr_n;
  logic              tdr_full, err_char;
  logic              tick, stepping, at_end, load, again, busy_n;
  logic              sample_now, tend_now, pull_n;

  sc_etu_tick #(.ETU_W(ETU_W)) u_tick (
    .clk        (clk),
    .rst        (rst),
    .run        (busy),
    .etu_cycles (etu_cycles),
    .tick       (tick)
  );

  always_comb begin
    hp_inc     = hp + HP_ONE;
    stepping   = busy && tick;
    end_pt     = (err_char || !guard_mode) ? HP_END_LNG : HP_END_G1;
    tend_pt    = guard_mode ? HP_TEND_G1 : HP_TEND_G0;
    at_end     = stepping && (hp_inc == end_pt);
    load       = tdr_full && (!busy || (at_end && !err_char));
    again      = at_end && err_char;
    busy_n     = load || again || (busy && !at_end);
    hp_n       = (load || again) ? '0 : (stepping ? hp_inc : hp);
    tsr_n      = load ? tdr : tsr;
    sample_now = stepping && (hp_inc == HP_SAMPLE);
    tend_now   = stepping && (hp_inc == tend_pt) && !err_char && !tdr_full;
  end

  sc_frame_gen #(.DATA_W(DATA_W), .SW(HP_W-1)) u_frame (
    .slot      (hp_n[HP_W-1:1]),
    .shreg     (tsr_n),
    .msb_first (msb_first),
    .pull      (pull_n)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy        <= 1'b0;
      hp          <= '0;
      tsr         <= '0;
      tdr         <= '0;
      tdr_full    <= 1'b0;
      err_char    <= 1'b0;
      io_pull_low <= 1'b0;
      txi         <= 1'b0;
      tend        <= 1'b1;
      tei         <= 1'b0;
      ers         <= 1'b0;
    end else begin
      busy        <= busy_n;
      hp          <= hp_n;
      tsr         <= tsr_n;
      io_pull_low <= busy_n && pull_n;
      txi         <= load;
      tei         <= tend_now;
      if (load || again)   err_char <= 1'b0;
      else if (sample_now) err_char <= !io_line;
      if (wr_en)     tdr_full <= 1'b1;
      else if (load) tdr_full <= 1'b0;
      if (wr_en) tdr <= wr_data;
      if (wr_en)         tend <= 1'b0;
      else if (tend_now) tend <= 1'b1;
      if (sample_now && !io_line) ers <= 1'b1;
      else if (err_clr)           ers <= 1'b0;
    end
  end

  assign tdr_empty = !tdr_full;
endmodule

// File: rtl/sc_char_tx_chk.sv
module sc_char_tx_chk (
  input logic clk,
  input logic rst,
  input logic wr_en,
  input logic err_clr,
  input logic io_pull_low,
  input logic busy,
  input logic tdr_empty,
  input logic txi,
  input logic tend,
  input logic tei,
  input logic ers
);
  // R3: the driver is only on inside a character slot
  a_r3_pull_needs_busy: assert property (@(posedge clk) disable iff (rst)
    io_pull_low |-> busy);

  // R1: a slot opened from idle starts with the low start bit
  a_r1_start_low: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> io_pull_low);

  // R5: leaving idle always comes with a load pulse
  a_r5_txi_on_start: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> txi);

  // R5: the load pulse lasts one cycle
  a_r5_txi_single: assert property (@(posedge clk) disable iff (rst)
    txi |=> !txi);

  // R5: a load frees the holding register unless a write met it
  a_r5_empty_after_load: assert property (@(posedge clk) disable iff (rst)
    txi && !$past(wr_en) |-> tdr_empty);

  // R6: a write clears the transmit-end flag
  a_r6_write_clears_tend: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> !tend);

  // R6: the end pulse accompanies a set flag
  a_r6_tei_with_tend: assert property (@(posedge clk) disable iff (rst)
    tei && !$past(wr_en) |-> tend);

  // R8: the error flag only falls on a clear request
  a_r8_ers_sticky: assert property (@(posedge clk) disable iff (rst)
    ers && !err_clr |=> ers);
endmodule

bind sc_char_tx sc_char_tx_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .wr_en       (wr_en),
  .err_clr     (err_clr),
  .io_pull_low (io_pull_low),
  .busy        (busy),
  .tdr_empty   (tdr_empty),
  .txi         (txi),
  .tend        (tend),
  .tei         (tei),
  .ers         (ers)
);

// File: tb/tb_sc_char_tx.sv
`timescale 1ns/1ps
module tb_sc_char_tx;
  localparam int ETU_W = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [ETU_W-1:0] etu_cycles = 6'd4;
  logic msb_first = 1'b0, guard_mode = 1'b0;
  logic wr_en = 1'b0, err_clr = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic rx_low = 1'b0;
  logic io_line, io_pull_low, busy, tdr_empty, txi, tend, tei, ers;

  always #2 clk = ~clk;

  assign io_line = !(io_pull_low || rx_low);

  sc_char_tx #(.DATA_W(8), .ETU_W(ETU_W)) dut (
    .clk(clk), .rst(rst), .etu_cycles(etu_cycles), .msb_first(msb_first),
    .guard_mode(guard_mode), .wr_en(wr_en), .wr_data(wr_data), .err_clr(err_clr),
    .io_line(io_line), .io_pull_low(io_pull_low), .busy(busy), .tdr_empty(tdr_empty),
    .txi(txi), .tend(tend), .tei(tei), .ers(ers)
  );

  int checks = 0, errors = 0;
  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int  half, m_t, attempts, writes, rej_left, rej_done;
  bit  m_act, m_full, m_echar, m_tend, m_tei, m_txi, m_ers, m_drive, m_rej, pre_full, pre_line;
  logic [7:0] m_tsr, m_tdr, cur_exp;
  logic [7:0] wq[$];

  function automatic bit model_drive();
    int b;
    if (!m_act) return 1'b0;
    b = (m_t / half) / 2;
    if (b == 0) return 1'b1;
    if (b <= 8) return msb_first ? !m_tsr[8-b] : !m_tsr[b-1];
    if (b == 9) return !(^m_tsr);
    return 1'b0;
  endfunction

  task automatic begin_attempt();
    m_t = 0; m_echar = 0; attempts++;
    m_rej = (rej_left > 0);
    if (m_rej) begin rej_left--; rej_done++; end
  endtask

  task automatic model_load();
    m_act = 1; m_tsr = m_tdr; m_full = 0; m_txi = 1;
    cur_exp = wq.pop_front();
    begin_attempt();
  endtask

  always @(posedge clk) begin
    half = int'(etu_cycles) / 2;
    m_txi = 0; m_tei = 0;
    if (rst) begin
      m_act = 0; m_full = 0; m_echar = 0; m_tend = 1; m_ers = 0; m_t = 0; m_drive = 0;
    end else begin
      pre_full = m_full; pre_line = io_line;
      if (err_clr) m_ers = 0;
      if (m_act) begin
        m_t++;
        if (m_t == 21 * half) begin
          m_echar = !pre_line;
          if (!pre_line) m_ers = 1;
        end
        if (m_t == (guard_mode ? 22 : 25) * half && !m_echar && !pre_full) begin
          m_tend = 1; m_tei = 1;
        end
        if (m_t == ((m_echar || !guard_mode) ? 26 : 24) * half) begin
          if (m_echar) begin_attempt();
          else if (pre_full) model_load();
          else m_act = 0;
        end
      end else if (pre_full) model_load();
      if (wr_en) begin m_tdr = wr_data; m_full = 1; m_tend = 0; end
      m_drive = model_drive();
    end
  end

  // ---------------- receiver, line decoder, per-cycle compare ----------------
  bit cmp_on = 0;
  int cyc = 0, last_txi = 0, txi_gap = 0, tei_gap = 0;
  logic [7:0] dec;

  always @(negedge clk) begin
    if (cmp_on) begin
      chk(io_pull_low == m_drive, (m_act && m_t >= 20 * half) ? "R3 released line" : "R1 line level",
          io_pull_low, m_drive);
      chk(busy == m_act, "R7 busy", busy, m_act);
      chk(tdr_empty == !m_full, "R5 tdr_empty", tdr_empty, !m_full);
      chk(txi == m_txi, "R5 txi", txi, m_txi);
      chk(tend == m_tend, "R6 tend", tend, m_tend);
      chk(tei == m_tei, "R6 tei", tei, m_tei);
      chk(ers == m_ers, "R8 ers", ers, m_ers);
      if (txi) begin txi_gap = cyc - last_txi; last_txi = cyc; end
      if (tei) tei_gap = cyc - last_txi;
      if (m_act && (m_t % half) == 0 && ((m_t / half) % 2) == 1) begin
        int slot;
        slot = (m_t / half) / 2;
        if (slot == 0) chk(io_line == 1'b0, "R1 start bit", io_line, 0);
        else if (slot <= 8) begin
          if (msb_first) dec[8-slot] = io_line; else dec[slot-1] = io_line;
        end else if (slot == 9) begin
          chk((^dec ^ io_line) == 1'b0, "R1 even parity", io_line, ^dec);
          chk(dec == cur_exp, msb_first ? "R2 msb-first byte" : "R2 lsb-first byte", dec, cur_exp);
        end
      end
    end
    rx_low = m_act && m_rej && m_t >= 20 * half + 1 && m_t < 23 * half;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 30000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 30000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic write_byte(input logic [7:0] b);
    while (!tdr_empty) @(negedge clk);
    wr_en = 1; wr_data = b; wq.push_back(b); writes++;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic wait_idle();
    while (m_act || m_full) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    attempts = 0; writes = 0; rej_left = 0; rej_done = 0;
    repeat (5) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(tend == 1'b1, "R6 reset tend", tend, 1);
    chk(tdr_empty == 1'b1, "R5 reset tdr_empty", tdr_empty, 1);
    chk(busy == 1'b0, "R7 reset busy", busy, 0);
    chk(ers == 1'b0, "R8 reset ers", ers, 0);
    cmp_on = 1;

    // etu 4, guard 0, lsb first, back-to-back bytes
    write_byte(8'hA5);
    write_byte(8'h3C);
    wait_idle();
    chk(txi_gap == 26 * 2, "R7 spacing guard0", txi_gap, 52);
    chk(tei_gap == 25 * 2, "R6 tend at 12.5 etu", tei_gap, 50);

    // two rejections of one byte
    rej_left = 2;
    write_byte(8'h81);
    wait_idle();
    chk(ers == 1'b1, "R4 ers after reject", ers, 1);
    chk(tei_gap == 26 * 2 * 2 + 25 * 2, "R4 resend slot 13 etu", tei_gap, 154);
    err_clr = 1; @(negedge clk); err_clr = 0;
    chk(ers == 1'b0, "R8 cleared", ers, 0);

    // etu 10, guard 1, msb first
    etu_cycles = 6'd10; msb_first = 1; guard_mode = 1;
    @(negedge clk);
    write_byte(8'hC3);
    wait_idle();
    chk(tei_gap == 22 * 5, "R9 tend at 11.0 etu, etu=10", tei_gap, 110);
    rej_left = 1;
    write_byte(8'h7E);
    write_byte(8'h01);
    repeat (200) @(negedge clk);
    err_clr = 1; @(negedge clk); err_clr = 0;
    wait_idle();
    chk(txi_gap == 26 * 5 + 24 * 5, "R7 spacing after resend, guard1", txi_gap, 250);
    chk(attempts == writes + rej_done, "R4 attempts", attempts, writes + rej_done);
    chk(rej_done == 3, "R4 rejections seen", rej_done, 3);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule